// File: doc/BRIEF.md
# Windowed Register File with Non-Halting Debug Read

This block is the integer register storage for a four-thread core that uses register windows. Each thread owns eight global registers, eight private local groups (one per window) and eight in/out groups that neighbouring windows share. The outs of window w and the ins of window w+1 are the same storage. Three architectural read ports take register numbers 0 to 31. All three use one shared thread select and one current-window pointer. A single write port, also addressed architecturally, loads contents.

A separate debug port reads raw physical storage without stopping the core. Its 5-bit index names a wordline and a half of a 144-bit physical row rather than an architectural register. A debugger can therefore inspect the globals, the current window's locals, and the odd-numbered and even-numbered in/out groups next to the current window. It does this through a decode that differs from the architectural numbering. Every read is synchronous, with one cycle of latency, and a debug read never alters any stored value.

Top module: `winrf_dbg`

## Requirements
- R1: While `rst` is high at a rising edge, every architectural read output and the debug output are zero after that edge.
- R2: A read address presented before a rising edge returns its data after that edge. When a write targets the same register in the same cycle, the read returns the old value and the new value appears one cycle later.
- R3: Architectural registers 0–7 are per-thread globals. They hold the same value whatever the window pointer is.
- R4: Out register 8+k read at window w is the same storage as in register 24+k at window (w+1) mod 8, including window 7 to window 0.
- R5: Local registers 16–23 are private to each window. A write to a local at one window leaves the locals of every other window unchanged.
- R6: Each of the four threads has separate storage. The three read ports and the debug port all use `rd_thr` and `cwp`, and the write port uses `wr_thr`, `wr_cwp` and `wr_addr`.
- R7: The debug index bits [4:1] form a wordline: 0–3 global, 4–7 odd group, 8–11 local, 12–15 even group. Bit [0] picks the half of the 144-bit row. The register within the group is k = index[2:0].
- R8: A debug index with wordline 0–3 returns global k. Wordline 8–11 returns local k of window `cwp`.
- R9: The odd wordlines return register k of the odd-numbered group among group `cwp` (ins) and group `cwp`+1 (outs): in k when `cwp` is odd, out k when it is even. The even wordlines return the other group: in k when `cwp` is even, out k when it is odd.
- R10: A debug read changes no stored value. Repeated reads of an unchanged location with no write return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| rd_thr | input | 2 | Thread used by all read ports and the debug port |
| cwp | input | 3 | Current window pointer for reads |
| rd_addr | input | 15 | Three 5-bit architectural register numbers, port 0 in bits [4:0] |
| rd_data | output | 216 | Three 72-bit read results, port 0 in bits [71:0] |
| dbg_idx | input | 5 | Debug physical index: wordline in [4:1], row half in [0] |
| dbg_data | output | 72 | Debug read result |
| wr_en | input | 1 | Write enable |
| wr_thr | input | 2 | Write thread |
| wr_cwp | input | 3 | Window pointer used to decode the write address |
| wr_addr | input | 5 | Architectural register number written |
| wr_data | input | 72 | Write data |

## Verification
Every read result, architectural or debug, is due exactly one rising edge after its address is presented. A write becomes visible to reads presented after the edge on which it lands. The bench drives all inputs on the falling edge and samples on the next falling edge, so exactly one register stage lies between stimulus and check. Same-cycle write and read collisions are checked on two successive falling edges, first for the old value and then for the new one. Reset is checked on the falling edge after a reset edge.

// File: rtl/winrf_pkg.sv
package winrf_pkg;

    localparam int unsigned REG_NUM_W = 5;
    localparam int unsigned GRP_REGS  = 8;
    localparam int unsigned GLB_REGS  = 8;

    typedef enum logic [1:0] {
        AC_GLOBAL = 2'd0,
        AC_OUT    = 2'd1,
        AC_LOCAL  = 2'd2,
        AC_IN     = 2'd3
    } arch_cls_e;

    typedef struct packed {
        arch_cls_e  cls;
        logic [2:0] k;
    } arch_reg_t;

    typedef enum logic [1:0] {
        DR_GLOBAL = 2'd0,
        DR_ODD    = 2'd1,
        DR_LOCAL  = 2'd2,
        DR_EVEN   = 2'd3
    } dbg_rgn_e;

    typedef struct packed {
        dbg_rgn_e   rgn;
        logic [2:0] k;
    } dbg_idx_t;

    function automatic int unsigned win_next(int unsigned w, int unsigned nwin);
        return (w + 1 == nwin) ? 0 : w + 1;
    endfunction

    function automatic int unsigned io_slot(int unsigned grp, int unsigned k);
        return GLB_REGS + grp * GRP_REGS + k;
    endfunction

    function automatic int unsigned loc_slot(int unsigned win, int unsigned k,
                                             int unsigned nwin);
        return GLB_REGS + nwin * GRP_REGS + win * GRP_REGS + k;
    endfunction

endpackage

// File: rtl/winrf_arch_dec.sv
module winrf_arch_dec
    import winrf_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned WIN_W  = 3,
    parameter int unsigned SLOT_W = 8
) (
    input  logic [WIN_W-1:0]  win,
    input  arch_reg_t         areg,
    output logic [SLOT_W-1:0] slot
);
    int unsigned w;
    int unsigned s;

    always_comb begin
        w = int'(win);
        unique case (areg.cls)
            AC_GLOBAL: s = int'(areg.k);
            AC_OUT:    s = io_slot(win_next(w, NWIN), int'(areg.k));
            AC_LOCAL:  s = loc_slot(w, int'(areg.k), NWIN);
            default:   s = io_slot(w, int'(areg.k));
        endcase
        slot = SLOT_W'(s);
    end

endmodule

// File: rtl/winrf_dbg_dec.sv
module winrf_dbg_dec
    import winrf_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned WIN_W  = 3,
    parameter int unsigned SLOT_W = 8
) (
    input  logic [WIN_W-1:0]  win,
    input  dbg_idx_t          idx,
    output logic [SLOT_W-1:0] slot
);
    int unsigned w;
    int unsigned nx;
    int unsigned s;

    always_comb begin
        w  = int'(win);
        nx = win_next(w, NWIN);
        unique case (idx.rgn)
            DR_GLOBAL: s = int'(idx.k);
            DR_LOCAL:  s = loc_slot(w, int'(idx.k), NWIN);
            DR_ODD:    s = io_slot(win[0] ? w : nx, int'(idx.k));
            default:   s = io_slot(win[0] ? nx : w, int'(idx.k));
        endcase
        slot = SLOT_W'(s);
    end

endmodule

// File: rtl/winrf_store.sv
module winrf_store #(
    parameter int unsigned DW     = 72,
    parameter int unsigned NTHR   = 4,
    parameter int unsigned NSLOT  = 136,
    parameter int unsigned NPORT  = 4,
    parameter int unsigned THR_W  = 2,
    parameter int unsigned SLOT_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [THR_W-1:0]             wr_thr,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  logic [DW-1:0]                wr_data,
    input  logic [THR_W-1:0]             rd_thr,
    input  logic [NPORT-1:0][SLOT_W-1:0] rd_slot,
    output logic [NPORT-1:0][DW-1:0]     rd_q
);
    localparam int unsigned DEPTH = NTHR * NSLOT;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    function automatic logic [IDX_W-1:0] flat(logic [THR_W-1:0] t, logic [SLOT_W-1:0] s);
        return IDX_W'(t) * IDX_W'(NSLOT) + IDX_W'(s);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[flat(wr_thr, wr_slot)] <= wr_data;
    end

    // checker state: captured every edge, armed one edge after reset leaves
    logic armed;
    logic last_wen;
    logic [THR_W-1:0] last_thr;
    always_ff @(posedge clk) begin
        armed    <= !rst;
        last_wen <= wr_en;
        last_thr <= rd_thr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) rd_q[p] <= '0;
            else     rd_q[p] <= mem[flat(rd_thr, rd_slot[p])];
        end

        logic [SLOT_W-1:0] last_slot;
        always_ff @(posedge clk) last_slot <= rd_slot[p];

        // R10: with no write, re-reading one location yields the same data
        assert_read_stable_R10: assert property (@(posedge clk) disable iff (rst)
            (armed && !last_wen && !wr_en && rd_slot[p] == last_slot && rd_thr == last_thr)
            |=> $stable(rd_q[p]));
    end

endmodule

// File: rtl/winrf_dbg.sv
module winrf_dbg
    import winrf_pkg::*;
#(
    parameter int unsigned NTHR = 4,
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 72,
    parameter int unsigned NRD  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(NTHR)-1:0]      rd_thr,
    input  logic [$clog2(NWIN)-1:0]      cwp,
    input  logic [NRD*REG_NUM_W-1:0]     rd_addr,
    output logic [NRD*DW-1:0]            rd_data,
    input  logic [REG_NUM_W-1:0]         dbg_idx,
    output logic [DW-1:0]                dbg_data,
    input  logic                         wr_en,
    input  logic [$clog2(NTHR)-1:0]      wr_thr,
    input  logic [$clog2(NWIN)-1:0]      wr_cwp,
    input  logic [REG_NUM_W-1:0]         wr_addr,
    input  logic [DW-1:0]                wr_data
);
    localparam int unsigned THR_W  = $clog2(NTHR);
    localparam int unsigned WIN_W  = $clog2(NWIN);
    localparam int unsigned NSLOT  = GLB_REGS + 2 * NWIN * GRP_REGS;
    localparam int unsigned SLOT_W = $clog2(NSLOT);
    localparam int unsigned NPORT  = NRD + 1;

    logic [NPORT-1:0][SLOT_W-1:0] slots;
    logic [NPORT-1:0][DW-1:0]     q;
    logic [SLOT_W-1:0]            wr_slot;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        winrf_arch_dec #(.NWIN(NWIN), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_dec (
            .win  (cwp),
            .areg (arch_reg_t'(rd_addr[p*REG_NUM_W +: REG_NUM_W])),
            .slot (slots[p])
        );
        assign rd_data[p*DW +: DW] = q[p];
    end

    winrf_dbg_dec #(.NWIN(NWIN), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_dbg_dec (
        .win  (cwp),
        .idx  (dbg_idx_t'(dbg_idx)),
        .slot (slots[NRD])
    );
    assign dbg_data = q[NRD];

    winrf_arch_dec #(.NWIN(NWIN), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_wr_dec (
        .win  (wr_cwp),
        .areg (arch_reg_t'(wr_addr)),
        .slot (wr_slot)
    );

    winrf_store #(
        .DW(DW), .NTHR(NTHR), .NSLOT(NSLOT), .NPORT(NPORT),
        .THR_W(THR_W), .SLOT_W(SLOT_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_thr  (wr_thr),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_thr  (rd_thr),
        .rd_slot (slots),
        .rd_q    (q)
    );

    // R1: reset clears every read output on the following edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && dbg_data == '0));

    // R8: debug global wordlines agree with the architectural global
    assert_dbg_global_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx[4:3] == 2'b00 && rd_addr[REG_NUM_W-1:0] == {2'b00, dbg_idx[2:0]})
        |=> dbg_data == rd_data[DW-1:0]);

    // R8: debug local wordlines agree with the local of the current window
    assert_dbg_local_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx[4:3] == 2'b10 && rd_addr[REG_NUM_W-1:0] == {2'b10, dbg_idx[2:0]})
        |=> dbg_data == rd_data[DW-1:0]);

    // R9: odd/even wordlines resolve to ins or outs by window parity
    assert_dbg_iogrp_R9: assert property (@(posedge clk) disable iff (rst)
        ((dbg_idx[4:3] == 2'b01 &&
          rd_addr[REG_NUM_W-1:0] == (cwp[0] ? {2'b11, dbg_idx[2:0]} : {2'b01, dbg_idx[2:0]})) ||
         (dbg_idx[4:3] == 2'b11 &&
          rd_addr[REG_NUM_W-1:0] == (cwp[0] ? {2'b01, dbg_idx[2:0]} : {2'b11, dbg_idx[2:0]})))
        |=> dbg_data == rd_data[DW-1:0]);

endmodule

// File: tb/sim_winrf_dbg.sv
module sim_winrf_dbg;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   rd_thr = '0;
    logic [2:0]   cwp = '0;
    logic [14:0]  rd_addr = '0;
    logic [215:0] rd_data;
    logic [4:0]   dbg_idx = '0;
    logic [71:0]  dbg_data;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_thr = '0;
    logic [2:0]   wr_cwp = '0;
    logic [4:0]   wr_addr = '0;
    logic [71:0]  wr_data = '0;

    always #4 clk = ~clk;

    winrf_dbg u0 (
        .clk(clk), .rst(rst), .rd_thr(rd_thr), .cwp(cwp), .rd_addr(rd_addr),
        .rd_data(rd_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .wr_en(wr_en), .wr_thr(wr_thr), .wr_cwp(wr_cwp), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // model[thread][kind: 0 global, 1 in/out group, 2 local][window or group][k]
    logic [71:0] model [4][3][8][8];

    function automatic logic [71:0] tag(int t, int kind, int w, int k);
        return {8'hC3, 40'h0, 8'(t), 8'(kind), 4'(w), 4'(k)};
    endfunction

    function automatic logic [71:0] exp_arch(int t, int c, int r);
        int k = r % 8;
        case (r / 8)
            0: return model[t][0][0][k];
            1: return model[t][1][(c + 1) % 8][k];
            2: return model[t][2][c][k];
            default: return model[t][1][c][k];
        endcase
    endfunction

    function automatic logic [71:0] exp_dbg(int t, int c, int idx);
        int k = idx % 8;
        case (idx / 8)
            0: return model[t][0][0][k];
            1: return model[t][1][(c % 2 == 1) ? c : (c + 1) % 8][k];
            2: return model[t][2][c][k];
            default: return model[t][1][(c % 2 == 0) ? c : (c + 1) % 8][k];
        endcase
    endfunction

    task automatic chk(string rq, string what, logic [71:0] act, logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic do_write(int t, int c, int r, logic [71:0] d);
        int k = r % 8;
        wr_en = 1'b1; wr_thr = 2'(t); wr_cwp = 3'(c); wr_addr = 5'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (r / 8)
            0: model[t][0][0][k] = d;
            1: model[t][1][(c + 1) % 8][k] = d;
            2: model[t][2][c][k] = d;
            default: model[t][1][c][k] = d;
        endcase
    endtask

    task automatic set_rd(int t, int c, int a0, int a1, int a2, int di);
        rd_thr = 2'(t); cwp = 3'(c);
        rd_addr = {5'(a2), 5'(a1), 5'(a0)};
        dbg_idx = 5'(di);
    endtask

    // {thread, cwp, addr0, addr1, addr2, debug index}
    localparam logic [24:0] VEC [8] = '{
        {2'd0, 3'd0, 5'd3,  5'd8,  5'd31, 5'b00101},
        {2'd0, 3'd7, 5'd9,  5'd24, 5'd16, 5'b01010},
        {2'd1, 3'd3, 5'd15, 5'd23, 5'd0,  5'b11111},
        {2'd2, 3'd4, 5'd12, 5'd20, 5'd28, 5'b01000},
        {2'd3, 3'd2, 5'd7,  5'd17, 5'd30, 5'b10011},
        {2'd3, 3'd6, 5'd14, 5'd22, 5'd25, 5'b11001},
        {2'd1, 3'd1, 5'd2,  5'd10, 5'd27, 5'b00000},
        {2'd2, 3'd5, 5'd11, 5'd19, 5'd26, 5'b10111}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: got running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero under reset
        chk("R1", "rd_data under reset", rd_data[71:0], 72'h0);
        chk("R1", "dbg_data under reset", dbg_data, 72'h0);
        rst = 1'b0;
        @(negedge clk);

        // fill: globals (written through varying windows), ins and locals per window
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 8; k++) do_write(t, (t + k) % 8, k, tag(t, 0, 0, k));
            for (int w = 0; w < 8; w++)
                for (int k = 0; k < 8; k++) begin
                    do_write(t, w, 24 + k, tag(t, 1, w, k));
                    do_write(t, w, 16 + k, tag(t, 2, w, k));
                end
        end

        // vector table: R3 R4 R5 R6 on the ports, R7 R8 R9 on debug
        for (int i = 0; i < 8; i++) begin
            logic [24:0] v = VEC[i];
            int t  = int'(v[24:23]);
            int c  = int'(v[22:20]);
            int a0 = int'(v[19:15]);
            int a1 = int'(v[14:10]);
            int a2 = int'(v[9:5]);
            int di = int'(v[4:0]);
            set_rd(t, c, a0, a1, a2, di);
            @(negedge clk);
            chk("R6", $sformatf("vec %0d port0", i), rd_data[71:0],    exp_arch(t, c, a0));
            chk("R4", $sformatf("vec %0d port1", i), rd_data[143:72],  exp_arch(t, c, a1));
            chk("R5", $sformatf("vec %0d port2", i), rd_data[215:144], exp_arch(t, c, a2));
            chk("R7", $sformatf("vec %0d debug", i), dbg_data,         exp_dbg(t, c, di));
        end

        // R3: global 4 identical at windows 0 and 6
        set_rd(2, 0, 4, 4, 4, 0);
        @(negedge clk);
        chk("R3", "global at cwp0", rd_data[71:0], tag(2, 0, 0, 4));
        set_rd(2, 6, 4, 4, 4, 0);
        @(negedge clk);
        chk("R3", "global at cwp6", rd_data[143:72], tag(2, 0, 0, 4));

        // R2: same-cycle write and read of local 2 at thread0 window3
        set_rd(0, 3, 18, 0, 0, 0);
        wr_en = 1'b1; wr_thr = 2'd0; wr_cwp = 3'd3; wr_addr = 5'd18; wr_data = 72'h5A_0000_0000_0000_1234;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2", "old value on collision", rd_data[71:0], tag(0, 2, 3, 2));
        model[0][2][3][2] = 72'h5A_0000_0000_0000_1234;
        @(negedge clk);
        chk("R2", "new value next cycle", rd_data[71:0], 72'h5A_0000_0000_0000_1234);

        // R4: wrap, out 5 at window 7 is in 5 at window 0
        do_write(3, 7, 13, 72'h77_0000_0000_0000_0705);
        set_rd(3, 0, 29, 13, 0, 5'b11101);
        @(negedge clk);
        chk("R4", "out of w7 seen as in of w0", rd_data[71:0], 72'h77_0000_0000_0000_0705);
        chk("R9", "even group at cwp0 is in", dbg_data, 72'h77_0000_0000_0000_0705);

        // R5: local write at window 4 leaves window 3 alone
        do_write(1, 4, 21, 72'h44_0000_0000_0000_0421);
        set_rd(1, 3, 21, 0, 0, 5'b10101);
        @(negedge clk);
        chk("R5", "local w3 unchanged", rd_data[71:0], tag(1, 2, 3, 5));
        chk("R8", "debug local w3", dbg_data, tag(1, 2, 3, 5));
        set_rd(1, 4, 21, 0, 0, 5'b10101);
        @(negedge clk);
        chk("R5", "local w4 updated", rd_data[71:0], 72'h44_0000_0000_0000_0421);

        // R6: thread1 global write leaves thread0
        do_write(1, 2, 4, 72'h11_0000_0000_0000_0004);
        set_rd(0, 2, 4, 0, 0, 5'b00100);
        @(negedge clk);
        chk("R6", "thread0 global unchanged", rd_data[71:0], tag(0, 0, 0, 4));
        chk("R6", "thread0 debug global", dbg_data, tag(0, 0, 0, 4));
        set_rd(1, 5, 4, 0, 0, 5'b00100);
        @(negedge clk);
        chk("R6", "thread1 global new", dbg_data, 72'h11_0000_0000_0000_0004);

        // R10: held debug read stays stable, then full sweep, then ports see no change
        set_rd(0, 3, 0, 0, 0, 5'b01110);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R10", "held debug read", dbg_data, exp_dbg(0, 3, 14));
        end
        for (int di = 0; di < 32; di++) begin
            set_rd(0, 3, 0, 0, 0, di);
            @(negedge clk);
            chk("R9", $sformatf("debug sweep idx %0d", di), dbg_data, exp_dbg(0, 3, di));
        end
        for (int r = 0; r < 32; r++) begin
            set_rd(0, 3, 0, 0, r, 0);
            @(negedge clk);
            chk("R10", $sformatf("arch after debug r%0d", r), rd_data[215:144], exp_arch(0, 3, r));
        end

        // R1: reset mid-run clears outputs
        set_rd(0, 3, 17, 17, 17, 5'b10001);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "rd_data after reset", rd_data[71:0], 72'h0);
        chk("R1", "dbg_data after reset", dbg_data, 72'h0);
        rst = 1'b0;

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule